// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer controlled through one 32-bit control/status register. A synchronous write strobe loads the register, and the read data is always present on the read port. A single-cycle reference tick input is divided by a selectable prescaler. Each prescaler period adds one count to a main counter.

When the count reaches the selected interval, the block sets an interrupt flag. It also drives a level interrupt output if interrupts are enabled. A fixed window of further counts then starts. If software has not restarted the counter when that window ends, and the reset-enable bit is set, the block issues a one-cycle system reset request and sets a reset flag. The flag is cleared only by the power-on reset, so it survives the system reset that the request causes. Software can pause counting and resume it without losing the elapsed time.

The divide ratios, the base and step of the interval exponent, and the window length are parameters. The requirements quote their default values.

Top module: `prescaled_watchdog`

## Requirements
- R1: After power-on reset the register reads 0x0000_0400: prescale select 1 and every other bit 0. The system reset (`rst_n`) restores the same value except for bit 2, which keeps its value. Only `por_n` clears bit 2.
- R2: Bits 11:10 select the prescale ratio. The values 0, 1, 2 and 3 select 1, 2^PS_SH1, 2^PS_SH2 and 2^PS_SH3 ticks per count (defaults 1, 256, 2048, 65536).
- R3: Bits 5:4 hold the interval select n. The interrupt flag (bit 3) reads 1 right after the tick that completes 2^(INT_BASE+INT_STEP*n) counts since the last restart (default 2^(14+2n)). It reads 0 after one tick fewer.
- R4: The interrupt flag sets whatever the value of the interrupt-enable bit (bit 6). `irq` is high exactly when bit 3 and bit 6 are both 1.
- R5: Bit 7 enables counting. While it is 0, ticks are ignored and the elapsed count is held. Setting it again resumes from the held count.
- R6: RST_WIN counts after the interrupt flag sets (default 1024), `rst_req` pulses for exactly one cycle, but only if reset-enable (bit 1) is 1 at that moment. Bit 6 has no effect on this.
- R7: Bit 2 (reset flag) reads 1 in the same cycle that `rst_req` is high, and keeps that value through `rst_n`.
- R8: Writing 1 to bit 3 or bit 2 clears that flag, and writing 0 leaves it unchanged. If hardware sets a flag in the same cycle, the set takes priority.
- R9: Writing 1 to bit 0 restarts the prescaler, the counter and any pending window, and discards a tick in the same cycle. Bit 0 always reads 0.
- R10: If bit 1 is 0 when the window ends, no request is made and bit 2 stays 0. A new interval then begins from a count of zero.
- R11: A write loads bits 11:10, 7, 6, 5:4 and 1 directly, and they read back as written. Bits 31:12, 9:8 and 0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous active-low; clears everything including the reset flag |
| rst_n | input | 1 | System reset, asynchronous active-low; clears everything except the reset flag |
| tick | input | 1 | One-cycle reference tick |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq | output | 1 | Level interrupt (flag and enable) |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
On every cycle, the assertions check four things: counters hold while counting is paused, a reset request is a single-cycle pulse, a request happens only with reset-enable set and always comes with the reset flag, and the interrupt flag rises only while counting is enabled. The exact interval for every prescale and interval pair cannot be shown by a property, and neither can the tick on which the flag turns, resuming after a pause, the flag surviving the system reset, or the next interval after a window ends without reset-enable. The bench scenarios cover these, with a behavioural model compared on every cycle. The bench uses reduced ratios and window so that every combination fits in a short run.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  localparam int unsigned BIT_RESTART = 0;
  localparam int unsigned BIT_RST_EN  = 1;
  localparam int unsigned BIT_RST_FLG = 2;
  localparam int unsigned BIT_INT_FLG = 3;
  localparam int unsigned BIT_IVL_LO  = 4;
  localparam int unsigned BIT_INT_EN  = 6;
  localparam int unsigned BIT_RUN     = 7;
  localparam int unsigned BIT_PS_LO   = 10;

  typedef struct packed {
    logic [1:0] psel;
    logic       run;
    logic       int_en;
    logic [1:0] isel;
    logic       rst_en;
  } wdt_cfg_t;

  localparam wdt_cfg_t CFG_RESET = '{psel: 2'd1, run: 1'b0, int_en: 1'b0,
                                     isel: 2'd0, rst_en: 1'b0};
endpackage

// File: rtl/wdt_rst_sync.sv
`timescale 1ns/1ps
module wdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/wdt_prescaler.sv
`timescale 1ns/1ps
module wdt_prescaler #(
  parameter int PS_SH1 = 8,
  parameter int PS_SH2 = 11,
  parameter int PS_SH3 = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       run,
  input  logic       clr,
  input  logic [1:0] sel,
  output logic       step
);
  localparam int PW = (PS_SH3 > 0) ? PS_SH3 : 1;
  localparam int SHIFTS [4] = '{0, PS_SH1, PS_SH2, PS_SH3};

  logic [PW-1:0] lim_tab [4];
  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          term;

  for (genvar g = 0; g < 4; g++) begin : g_lim
    assign lim_tab[g] = PW'((64'd1 << SHIFTS[g]) - 64'd1);
  end

  always_comb begin
    term   = (pcnt_q >= lim_tab[sel]);
    step   = run && tick && !clr && term;
    pcnt_d = pcnt_q;
    if (clr)              pcnt_d = '0;
    else if (run && tick) pcnt_d = term ? '0 : pcnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R5: paused and not restarted, the prescaler holds its phase
  p_prescale_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(pcnt_q));
endmodule

// File: rtl/wdt_timeout.sv
`timescale 1ns/1ps
module wdt_timeout #(
  parameter int INT_BASE = 14,
  parameter int INT_STEP = 2,
  parameter int RST_WIN  = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       clr,
  input  logic [1:0] isel,
  input  logic       rst_en,
  output logic       hit,
  output logic       fire,
  output logic       rst_req
);
  localparam int CW = INT_BASE + 3 * INT_STEP + 1;
  localparam logic [CW-1:0] WIN_LAST = CW'(RST_WIN - 1);

  logic [CW-1:0] thr_tab [4];
  logic [CW-1:0] cnt_q, cnt_d;
  logic          armed_q, armed_d;
  logic          req_q;

  for (genvar g = 0; g < 4; g++) begin : g_thr
    assign thr_tab[g] = CW'((64'd1 << (INT_BASE + INT_STEP * g)) - 64'd1);
  end

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    hit     = 1'b0;
    fire    = 1'b0;
    if (clr) begin
      cnt_d   = '0;
      armed_d = 1'b0;
    end else if (step) begin
      if (!armed_q) begin
        if (cnt_q >= thr_tab[isel]) begin
          cnt_d   = '0;
          armed_d = 1'b1;
          hit     = 1'b1;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end else begin
        if (cnt_q >= WIN_LAST) begin
          cnt_d   = '0;
          armed_d = 1'b0;
          fire    = rst_en;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      req_q   <= fire;
    end
  end

  assign rst_req = req_q;

  // R6: the request lasts a single cycle
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R6: a request needs reset-enable in the cycle that ended the window
  p_req_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(rst_en));
  // R5: without a count or a restart the interval state is frozen
  p_count_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> ($stable(cnt_q) && $stable(armed_q)));
endmodule

// File: rtl/prescaled_watchdog.sv
`timescale 1ns/1ps
module prescaled_watchdog
  import wdt_pkg::*;
#(
  parameter int PS_SH1   = 8,
  parameter int PS_SH2   = 11,
  parameter int PS_SH3   = 16,
  parameter int INT_BASE = 14,
  parameter int INT_STEP = 2,
  parameter int RST_WIN  = 1024
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        rst_req
);
  logic     sys_arst_n, core_rst_n, flag_rst_n;
  wdt_cfg_t cfg_q, cfg_d;
  logic     iflag_q, iflag_d, rflag_q, rflag_d;
  logic     restart, step, hit, fire;
  logic     unused_wdata;

  assign sys_arst_n   = por_n & rst_n;
  assign unused_wdata = ^{reg_wdata[31:12], reg_wdata[9:8]};

  wdt_rst_sync #(.STAGES(2)) u_core_sync (
    .clk(clk), .arst_n(sys_arst_n), .srst_n(core_rst_n));
  wdt_rst_sync #(.STAGES(2)) u_flag_sync (
    .clk(clk), .arst_n(por_n), .srst_n(flag_rst_n));

  wdt_prescaler #(.PS_SH1(PS_SH1), .PS_SH2(PS_SH2), .PS_SH3(PS_SH3)) u_pre (
    .clk(clk), .rst_n(core_rst_n), .tick(tick), .run(cfg_q.run),
    .clr(restart), .sel(cfg_q.psel), .step(step));

  wdt_timeout #(.INT_BASE(INT_BASE), .INT_STEP(INT_STEP), .RST_WIN(RST_WIN)) u_tmo (
    .clk(clk), .rst_n(core_rst_n), .step(step), .clr(restart),
    .isel(cfg_q.isel), .rst_en(cfg_q.rst_en), .hit(hit), .fire(fire),
    .rst_req(rst_req));

  always_comb begin
    restart      = reg_wr && reg_wdata[BIT_RESTART];
    cfg_d.psel   = reg_wdata[BIT_PS_LO +: 2];
    cfg_d.run    = reg_wdata[BIT_RUN];
    cfg_d.int_en = reg_wdata[BIT_INT_EN];
    cfg_d.isel   = reg_wdata[BIT_IVL_LO +: 2];
    cfg_d.rst_en = reg_wdata[BIT_RST_EN];
    iflag_d = iflag_q;
    if (reg_wr && reg_wdata[BIT_INT_FLG]) iflag_d = 1'b0;
    if (hit)                              iflag_d = 1'b1;
    rflag_d = rflag_q;
    if (reg_wr && reg_wdata[BIT_RST_FLG]) rflag_d = 1'b0;
    if (fire)                             rflag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      cfg_q   <= CFG_RESET;
      iflag_q <= 1'b0;
    end else begin
      if (reg_wr) cfg_q <= cfg_d;
      iflag_q <= iflag_d;
    end
  end

  always_ff @(posedge clk or negedge flag_rst_n) begin
    if (!flag_rst_n) rflag_q <= 1'b0;
    else             rflag_q <= rflag_d;
  end

  always_comb begin
    reg_rdata                   = '0;
    reg_rdata[BIT_PS_LO +: 2]   = cfg_q.psel;
    reg_rdata[BIT_RUN]          = cfg_q.run;
    reg_rdata[BIT_INT_EN]       = cfg_q.int_en;
    reg_rdata[BIT_IVL_LO +: 2]  = cfg_q.isel;
    reg_rdata[BIT_INT_FLG]      = iflag_q;
    reg_rdata[BIT_RST_FLG]      = rflag_q;
    reg_rdata[BIT_RST_EN]       = cfg_q.rst_en;
  end

  assign irq = iflag_q & cfg_q.int_en;

  // R7: the reset flag is visible whenever a request is issued
  p_flag_with_req_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    rst_req |-> rflag_q);
  // R5: a timeout can only come out of an enabled counter
  p_iflag_needs_run_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(iflag_q) |-> $past(cfg_q.run));
endmodule

// File: tb/prescaled_watchdog_test.sv
`timescale 1ns/1ps
module prescaled_watchdog_test;
  localparam int SH1 = 2, SH2 = 3, SH3 = 4;
  localparam int IB = 4, IS = 2, WIN = 8;
  localparam logic [31:0] EN = 32'h80, IE = 32'h40, IFL = 32'h8, RFL = 32'h4;
  localparam logic [31:0] REN = 32'h2, RS = 32'h1;

  logic        clk, por_n, rst_n, tick, reg_wr, irq, rst_req;
  logic [31:0] reg_wdata, reg_rdata;
  int n_run = 0, n_fail = 0, req_cnt = 0;

  prescaled_watchdog #(.PS_SH1(SH1), .PS_SH2(SH2), .PS_SH3(SH3),
    .INT_BASE(IB), .INT_STEP(IS), .RST_WIN(WIN)) uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .rst_req(rst_req));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int ratio(int p);
    int sh [4] = '{0, SH1, SH2, SH3};
    return 1 << sh[p];
  endfunction
  function automatic int ivl(int n);
    return 1 << (IB + IS * n);
  endfunction

  // behavioural reference model, elapsed enabled ticks since restart
  int m_psel, m_en, m_ie, m_isel, m_if, m_rf, m_re, m_et, m_rel, m_rr;
  function automatic logic [31:0] m_rdata();
    return 32'((m_psel << 10) | (m_en << 7) | (m_ie << 6) | (m_isel << 4) |
               (m_if << 3) | (m_rf << 2) | (m_re << 1));
  endfunction
  task automatic m_core_reset();
    m_psel = 1; m_en = 0; m_ie = 0; m_isel = 0; m_if = 0; m_re = 0;
    m_et = 0; m_rr = 0;
  endtask

  always @(posedge clk) begin : ref_model
    int s, pos, set_if, set_rf;
    if (!por_n) m_rf = 0;
    if (!por_n || !rst_n) begin
      m_rel = 0; m_core_reset();
    end else if (m_rel < 2) begin
      m_rel++; m_core_reset();
    end else begin
      m_rr = 0; set_if = 0; set_rf = 0;
      if (reg_wr && reg_wdata[0]) m_et = 0;
      else if (m_en != 0 && tick) begin
        m_et++;
        if (m_et % ratio(m_psel) == 0) begin
          s = m_et / ratio(m_psel);
          pos = s % (ivl(m_isel) + WIN);
          if (pos == ivl(m_isel)) set_if = 1;
          if (pos == 0 && m_re != 0) begin set_rf = 1; m_rr = 1; end
        end
      end
      if (reg_wr) begin
        m_psel = int'(reg_wdata[11:10]); m_en = int'(reg_wdata[7]);
        m_ie = int'(reg_wdata[6]); m_isel = int'(reg_wdata[5:4]);
        m_re = int'(reg_wdata[1]);
        if (reg_wdata[3]) m_if = 0;
        if (reg_wdata[2]) m_rf = 0;
      end
      if (set_if != 0) m_if = 1;
      if (set_rf != 0) m_rf = 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_req) req_cnt++;
    if (por_n && rst_n) begin
      chk("R11 model rdata", reg_rdata, m_rdata());
      chk("R4 model irq", {31'd0, irq}, 32'(m_if & m_ie));
      chk("R6 model rst_req", {31'd0, rst_req}, 32'(m_rr));
    end
  end

  task automatic wr(input logic [31:0] d);
    reg_wr = 1'b1; reg_wdata = d; @(negedge clk); reg_wr = 1'b0;
  endtask
  task automatic wr_tick(input logic [31:0] d);
    reg_wr = 1'b1; tick = 1'b1; reg_wdata = d; @(negedge clk);
    reg_wr = 1'b0; tick = 1'b0;
  endtask
  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin tick = 1'b1; @(negedge clk); end
    tick = 1'b0;
  endtask

  task automatic fire_reset();
    req_cnt = 0;
    wr(EN | REN | IFL | RFL | RS);
    run(ivl(0));
    chk("R4 flag without enable", {31'd0, reg_rdata[3]}, 32'd1);
    chk("R4 irq masked", {31'd0, irq}, 32'd0);
    run(WIN - 1);
    chk("R6 no request before window end", {31'd0, rst_req}, 32'd0);
    run(1);
    chk("R6 request at window end", {31'd0, rst_req}, 32'd1);
    chk("R7 flag with request", {31'd0, reg_rdata[2]}, 32'd1);
    @(negedge clk);
    chk("R6 single pulse", {31'd0, rst_req}, 32'd0);
    chk("R6 pulse count", 32'(req_cnt), 32'd1);
  endtask

  initial begin
    por_n = 1'b0; rst_n = 1'b0; tick = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset value", reg_rdata, 32'h400);
    chk("R1 irq low", {31'd0, irq}, 32'd0);

    wr(32'h400 | RFL | IFL | RS);
    chk("R9 restart reads zero", reg_rdata, 32'h400);

    wr(32'hFFFF_FFFE);
    chk("R11 readback", reg_rdata, 32'h0000_0CF2);
    wr(RS);
    chk("R11 cleared", reg_rdata, 32'h0);

    for (int p = 0; p < 4; p++) begin
      for (int n = 0; n < 4; n++) begin
        wr(32'(p << 10) | EN | IE | 32'(n << 4) | IFL | RS);
        run(ivl(n) * ratio(p) - 1);
        chk($sformatf("R3 early p=%0d n=%0d", p, n), {31'd0, reg_rdata[3]}, 32'd0);
        chk("R2 irq early", {31'd0, irq}, 32'd0);
        run(1);
        chk($sformatf("R2 timeout p=%0d n=%0d", p, n), {31'd0, reg_rdata[3]}, 32'd1);
        chk("R4 irq on timeout", {31'd0, irq}, 32'd1);
      end
    end

    req_cnt = 0;
    wr(EN | IFL | RFL | RS);
    run(ivl(0));
    chk("R4 flag, irq masked", {31'd0, reg_rdata[3], irq}, 32'd2);
    run(WIN);
    chk("R10 no request", 32'(req_cnt), 32'd0);
    chk("R10 reset flag stays 0", {31'd0, reg_rdata[2]}, 32'd0);
    wr(EN | IFL);
    run(ivl(0) - 1);
    chk("R10 next interval early", {31'd0, reg_rdata[3]}, 32'd0);
    run(1);
    chk("R10 next interval", {31'd0, reg_rdata[3]}, 32'd1);

    wr(EN | IE | IFL | RS);
    run(ivl(0) + WIN);
    chk("R6 interrupt only, no request", 32'(req_cnt), 32'd0);
    chk("R4 irq with enable", {31'd0, irq}, 32'd1);

    wr(EN | IE | IFL | RS);
    run(10);
    wr(EN | IE | RS);
    chk("R9 bit0 reads 0", {31'd0, reg_rdata[0]}, 32'd0);
    run(ivl(0) - 1);
    chk("R9 restart reloads interval", {31'd0, reg_rdata[3]}, 32'd0);
    run(1);
    chk("R9 full interval after restart", {31'd0, reg_rdata[3]}, 32'd1);

    wr(EN | IE | IFL | RS);
    run(ivl(0) - 1);
    wr_tick(EN | IE | IFL);
    chk("R8 hardware set wins", {31'd0, reg_rdata[3]}, 32'd1);

    wr(EN | IE | IFL | RS);
    run(ivl(0) / 2);
    wr(IE);
    chk("R5 paused", reg_rdata, IE);
    run(200);
    chk("R5 no timeout while paused", reg_rdata, IE);
    chk("R5 irq low while paused", {31'd0, irq}, 32'd0);
    wr(EN | IE);
    run(ivl(0) / 2 - 1);
    chk("R5 resume keeps progress", {31'd0, reg_rdata[3]}, 32'd0);
    run(1);
    chk("R5 resume fires", reg_rdata, EN | IE | IFL);

    fire_reset();
    rst_n = 1'b0; repeat (2) @(negedge clk);
    rst_n = 1'b1; repeat (3) @(negedge clk);
    chk("R7 flag survives system reset", reg_rdata, 32'h404);
    wr(32'h400 | RFL);
    chk("R8 write-1 clears reset flag", reg_rdata, 32'h400);

    fire_reset();
    por_n = 1'b0; repeat (2) @(negedge clk);
    por_n = 1'b1; repeat (3) @(negedge clk);
    chk("R1 power-on clears reset flag", reg_rdata, 32'h400);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog expired (R3 timing)");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule